// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer Model

This block is a synthesizable behavioural model of a byte-wide parallel NOR flash that a processor reprograms through its own bus. It watches write cycles for the standard two-write unlock key, interprets the command byte that follows, and then carries out a byte program, a 4 KB sector erase or a whole-array erase on an internal byte array of parameterizable depth. Bank decoding on the processor side is outside the block: it sees a 19-bit flash address directly.

An operation keeps the part busy for a parameterizable number of cycles. During that time every read returns a status byte in place of array data. Bit 6 of that byte flips on each read, so software that reads the same location until two reads agree knows the operation has finished and sees the final stored value.

Bus strobes are active high and sampled on the rising clock edge: a write cycle is `cs & we`, a read cycle is `cs & oe & ~we`. Command addresses are compared on flash address bits 14:0 only. Array bytes are selected by address bits `MEM_AW-1:0`, so higher bits alias.

Top module: `flash_seq_model`

## Requirements
- R1: After reset `dout` is 0x00, no operation is in progress and the command decoder waits for the first unlock write.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then a data byte to a target address start a byte program. The part is busy from the edge after the final write for `PROG_CYCLES` cycles. Only address bits 14:0 take part in the key comparison.
- R3: A program stores the bitwise AND of the old byte and the new data, so it can only clear bits.
- R4: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 to any address erase the aligned block of 2^`SECTOR_AW` bytes holding that address to 0xFF and leave every other byte unchanged. The part stays busy for max(`SECT_CYCLES`, 2^`SECTOR_AW`) cycles.
- R5: The same erase prefix followed by 0x10 written to 0x5555 sets every byte of the array to 0xFF. The part stays busy for max(`CHIP_CYCLES`, 2^`MEM_AW`) cycles.
- R6: A write that does not match the next expected step returns the decoder to its waiting state, and no operation starts. A correct sequence issued right afterwards is accepted.
- R7: A read while busy returns a status byte with bits 5:0 equal to zero and bit 6 inverted from the previous busy read.
- R8: Status bit 7 is the complement of bit 7 of the data being programmed during a program, and 0 during either erase.
- R9: Writes issued while busy change neither the array nor the decoder's progress through a sequence.
- R10: A read while not busy loads `dout`, at the edge of the read cycle, with the byte at address bits `MEM_AW-1:0`. `dout` holds its value when no read takes place.
- R11: Reading a location repeatedly until two consecutive reads match yields 0xFF after an erase and the stored byte after a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| we | input | 1 | Write strobe, active high |
| oe | input | 1 | Read strobe, active high |
| addr | input | 19 | Flash byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data or status byte |

## Verification
The bench builds the block with a 1 KB array (`MEM_AW`=10), 256-byte sectors (`SECTOR_AW`=8), `PROG_CYCLES`=20, `SECT_CYCLES`=16 and `CHIP_CYCLES`=8. The small array lets a full-array erase finish in about a thousand cycles. The small sector puts several sectors side by side, so an erase can be shown to stop at its boundaries. The short erase cycle counts let the sweep span decide the busy length. The long program time leaves room for a complete command sequence to arrive while the part is busy, which is where R9 is exercised.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int KEY_W = 15;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_DATA_A  = 8'hAA;
    localparam logic [7:0] KEY_DATA_B  = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_WHOLE   = 8'h10;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_KEY1,
        SEQ_KEY2,
        SEQ_PDATA,
        SEQ_EKEY0,
        SEQ_EKEY1,
        SEQ_ECMD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_e;

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             busy,
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       din,
    output op_kind_e         start_op
);

    typedef struct packed {
        seq_state_e state;
    } dec_regs_t;

    dec_regs_t dec_d, dec_q;

    logic hit_a, hit_b;

    always_comb begin
        hit_a    = (key_addr == KEY_ADDR_A);
        hit_b    = (key_addr == KEY_ADDR_B);
        dec_d    = dec_q;
        start_op = OP_NONE;
        if (wr_en && !busy) begin
            dec_d.state = SEQ_IDLE;
            case (dec_q.state)
                SEQ_IDLE:
                    if (hit_a && din == KEY_DATA_A) dec_d.state = SEQ_KEY1;
                SEQ_KEY1:
                    if (hit_b && din == KEY_DATA_B) dec_d.state = SEQ_KEY2;
                SEQ_KEY2:
                    if (hit_a && din == CMD_PROGRAM)    dec_d.state = SEQ_PDATA;
                    else if (hit_a && din == CMD_ERASE) dec_d.state = SEQ_EKEY0;
                SEQ_PDATA:
                    start_op = OP_PROG;
                SEQ_EKEY0:
                    if (hit_a && din == KEY_DATA_A) dec_d.state = SEQ_EKEY1;
                SEQ_EKEY1:
                    if (hit_b && din == KEY_DATA_B) dec_d.state = SEQ_ECMD;
                SEQ_ECMD:
                    if (hit_a && din == CMD_WHOLE)   start_op = OP_CHIP;
                    else if (din == CMD_SECTOR)      start_op = OP_SECT;
                default: dec_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '{state: SEQ_IDLE};
        else        dec_q <= dec_d;
    end

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(dec_q.state));

    assert_start_only_on_data_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_op != OP_NONE) |=> (dec_q.state == SEQ_IDLE));

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_seq_pkg::*;
#(
    parameter int MEM_AW    = 12,
    parameter int SECT_BITS = 12,
    parameter int PROG_LEN  = 8,
    parameter int SECT_LEN  = 4096,
    parameter int CHIP_LEN  = 4096,
    parameter int CNT_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_kind_e          start_op,
    input  logic [MEM_AW-1:0] start_addr,
    input  logic [7:0]        start_data,
    output logic              busy,
    output logic              status_b7,
    output logic              mem_we,
    output logic              mem_and,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic [7:0]        prog_data
);

    localparam int SECT_SPAN = 1 << SECT_BITS;
    localparam int CHIP_SPAN = 1 << MEM_AW;
    localparam logic [MEM_AW-1:0] SMASK = MEM_AW'((1 << SECT_BITS) - 1);

    typedef struct packed {
        logic              busy;
        op_kind_e          op;
        logic [CNT_W-1:0]  cnt;
        logic [MEM_AW-1:0] tgt;
        logic [7:0]        data;
    } eng_regs_t;

    eng_regs_t eng_d, eng_q;
    logic      last;

    always_comb begin
        case (eng_q.op)
            OP_PROG: last = (eng_q.cnt == CNT_W'(PROG_LEN - 1));
            OP_SECT: last = (eng_q.cnt == CNT_W'(SECT_LEN - 1));
            OP_CHIP: last = (eng_q.cnt == CNT_W'(CHIP_LEN - 1));
            default: last = 1'b1;
        endcase

        eng_d = eng_q;
        if (eng_q.busy) begin
            if (last) begin
                eng_d.busy = 1'b0;
                eng_d.op   = OP_NONE;
            end else begin
                eng_d.cnt = eng_q.cnt + 1'b1;
            end
        end else if (start_op != OP_NONE) begin
            eng_d.busy = 1'b1;
            eng_d.op   = start_op;
            eng_d.cnt  = '0;
            eng_d.tgt  = start_addr;
            eng_d.data = start_data;
        end

        mem_we    = 1'b0;
        mem_and   = 1'b0;
        mem_waddr = eng_q.tgt;
        if (eng_q.busy) begin
            case (eng_q.op)
                OP_PROG: begin
                    mem_we  = last;
                    mem_and = 1'b1;
                end
                OP_SECT: begin
                    mem_we    = (eng_q.cnt < CNT_W'(SECT_SPAN));
                    mem_waddr = (eng_q.tgt & ~SMASK) | (eng_q.cnt[MEM_AW-1:0] & SMASK);
                end
                OP_CHIP: begin
                    mem_we    = (eng_q.cnt < CNT_W'(CHIP_SPAN));
                    mem_waddr = eng_q.cnt[MEM_AW-1:0];
                end
                default: mem_we = 1'b0;
            endcase
        end

        busy      = eng_q.busy;
        status_b7 = (eng_q.op == OP_PROG) ? ~eng_q.data[7] : 1'b0;
        prog_data = eng_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{busy: 1'b0, op: OP_NONE, cnt: '0, tgt: '0, data: '0};
        else        eng_q <= eng_d;
    end

    assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_op != OP_NONE) |-> !eng_q.busy);

    assert_start_raises_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_op != OP_NONE) |=> eng_q.busy);

    assert_writes_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> eng_q.busy);

endmodule

// File: rtl/flash_seq_model.sv
module flash_seq_model
    import flash_seq_pkg::*;
#(
    parameter int MEM_AW      = 12,
    parameter int SECTOR_AW   = 12,
    parameter int PROG_CYCLES = 8,
    parameter int SECT_CYCLES = 64,
    parameter int CHIP_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        we,
    input  logic        oe,
    input  logic [18:0] addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout
);

    localparam int ADDR_W    = 19;
    localparam int DEPTH     = 1 << MEM_AW;
    localparam int SECT_BITS = (SECTOR_AW < MEM_AW) ? SECTOR_AW : MEM_AW;
    localparam int SECT_SPAN = 1 << SECT_BITS;
    localparam int PROG_LEN  = (PROG_CYCLES > 0) ? PROG_CYCLES : 1;
    localparam int SECT_LEN  = (SECT_CYCLES > SECT_SPAN) ? SECT_CYCLES : SECT_SPAN;
    localparam int CHIP_LEN  = (CHIP_CYCLES > DEPTH) ? CHIP_CYCLES : DEPTH;
    localparam int MAX_LEN   = (CHIP_LEN > PROG_LEN) ? CHIP_LEN : PROG_LEN;
    localparam int CNT_W     = $clog2(MAX_LEN) + 1;

    typedef struct packed {
        logic [7:0] dout;
        logic       tog;
    } rd_regs_t;

    rd_regs_t rd_d, rd_q;

    logic [7:0]        mem [DEPTH];
    logic              wr_en, rd_en;
    op_kind_e          start_op;
    logic              busy, status_b7, mem_we, mem_and;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0]        prog_data;
    logic              unused_addr_hi;

    assign wr_en          = cs && we;
    assign rd_en          = cs && oe && !we;
    assign unused_addr_hi = ^addr[ADDR_W-1:KEY_W];

    flash_cmd_decoder u_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .key_addr (addr[KEY_W-1:0]),
        .din      (din),
        .start_op (start_op)
    );

    flash_op_engine #(
        .MEM_AW    (MEM_AW),
        .SECT_BITS (SECT_BITS),
        .PROG_LEN  (PROG_LEN),
        .SECT_LEN  (SECT_LEN),
        .CHIP_LEN  (CHIP_LEN),
        .CNT_W     (CNT_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_op   (start_op),
        .start_addr (addr[MEM_AW-1:0]),
        .start_data (din),
        .busy       (busy),
        .status_b7  (status_b7),
        .mem_we     (mem_we),
        .mem_and    (mem_and),
        .mem_waddr  (mem_waddr),
        .prog_data  (prog_data)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            if (busy) begin
                rd_d.dout = {status_b7, rd_q.tog, 6'b0};
                rd_d.tog  = ~rd_q.tog;
            end else begin
                rd_d.dout = mem[addr[MEM_AW-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '{dout: 8'h00, tog: 1'b0};
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_and ? (mem[mem_waddr] & prog_data) : 8'hFF;
    end

    assign dout = rd_q.dout;

    logic seen_busy_rd_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_busy_rd_q <= 1'b0;
        else if (rd_en && busy)    seen_busy_rd_q <= 1'b1;
        else if (rd_en)            seen_busy_rd_q <= 1'b0;
    end

    assert_status_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (dout[5:0] == 6'b0));

    assert_status_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && seen_busy_rd_q) |=> (dout[6] != $past(dout[6])));

    assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(dout));

endmodule

// File: tb/test_flash_seq_model.sv
module test_flash_seq_model;

    localparam int MAW   = 10;
    localparam int SAW   = 8;
    localparam int PLEN  = 20;
    localparam int SLEN  = 256;
    localparam int CLEN  = 1024;
    localparam int DEPTH = 1 << MAW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0, oe = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    flash_seq_model #(
        .MEM_AW(MAW), .SECTOR_AW(SAW), .PROG_CYCLES(PLEN),
        .SECT_CYCLES(16), .CHIP_CYCLES(8)
    ) i_flash_seq_model (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .oe(oe),
        .addr(addr), .din(din), .dout(dout)
    );

    // Behavioural reference model
    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_dout;
    logic       m_tog;
    int         m_state, m_left, m_op, m_tgt;
    logic [7:0] m_data;
    logic       mw, mr, ka, kb;

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_tog = 1'b0; m_dout = 8'h00; m_op = 0;
        end else begin
            mw = cs && we;
            mr = cs && oe && !we;
            ka = (addr[14:0] == 15'h5555);
            kb = (addr[14:0] == 15'h2AAA);
            if (mr) begin
                if (m_left > 0) begin
                    m_dout = {(m_op == 1) ? ~m_data[7] : 1'b0, m_tog, 6'b0};
                    m_tog  = ~m_tog;
                end else begin
                    m_dout = m_mem[addr[MAW-1:0]];
                end
            end
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_op == 1) m_mem[m_tgt] = m_mem[m_tgt] & m_data;
                    else if (m_op == 2) begin
                        for (int i = 0; i < (1 << SAW); i++)
                            m_mem[(m_tgt & ~((1 << SAW) - 1)) + i] = 8'hFF;
                    end else begin
                        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                    end
                end
            end else if (mw) begin
                case (m_state)
                    0: m_state = (ka && din == 8'hAA) ? 1 : 0;
                    1: m_state = (kb && din == 8'h55) ? 2 : 0;
                    2: m_state = (ka && din == 8'hA0) ? 3 : (ka && din == 8'h80) ? 4 : 0;
                    3: begin
                        m_op = 1; m_tgt = int'(addr[MAW-1:0]); m_data = din;
                        m_left = PLEN; m_state = 0;
                    end
                    4: m_state = (ka && din == 8'hAA) ? 5 : 0;
                    5: m_state = (kb && din == 8'h55) ? 6 : 0;
                    default: begin
                        if (ka && din == 8'h10) begin
                            m_op = 3; m_left = CLEN;
                        end else if (din == 8'h30) begin
                            m_op = 2; m_tgt = int'(addr[MAW-1:0]); m_left = SLEN;
                        end
                        m_state = 0;
                    end
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison (R10 registered read path)
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            n_tests++;
            if (dout !== m_dout) begin
                n_fail++;
                $display("FAIL R10 model compare: act=%02h exp=%02h", dout, m_dout);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        cs = 1'b1; we = 1'b1; oe = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        cs = 1'b1; we = 1'b0; oe = 1'b1; addr = a;
        @(negedge clk);
        v = dout;
        cs = 1'b0; oe = 1'b0;
    endtask

    task automatic poll(input logic [18:0] a, output logic [7:0] v);
        logic [7:0] prev, cur;
        rd(a, prev);
        for (int i = 0; i < 4000; i++) begin
            rd(a, cur);
            if (cur == prev) break;
            prev = cur;
        end
        v = cur;
    endtask

    task automatic unlock(input logic [18:0] base);
        wr(base | 19'h05555, 8'hAA);
        wr(base | 19'h02AAA, 8'h55);
    endtask

    task automatic program_byte(input logic [18:0] a, input logic [7:0] d);
        unlock(19'h0);
        wr(19'h05555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_prefix();
        unlock(19'h0);
        wr(19'h05555, 8'h80);
        unlock(19'h0);
    endtask

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset dout", dout, 8'h00);

        // R5 whole-array erase
        erase_prefix();
        wr(19'h05555, 8'h10);
        rd(19'h000, v);
        chk("R8 erase status bit7", {7'b0, v[7]}, 8'h00);
        poll(19'h000, v);
        chk("R5 chip erase byte 0", v, 8'hFF);
        rd(19'h3FF, v);
        chk("R5 chip erase last byte", v, 8'hFF);

        // R2 program, R7/R8 status
        program_byte(19'h123, 8'h3C);
        rd(19'h123, v);
        rd(19'h123, v2);
        chk("R8 program status bit7", {7'b0, v[7]}, 8'h01);
        chk("R7 bit6 toggles", {7'b0, v[6] ^ v2[6]}, 8'h01);
        chk("R7 low bits zero", {2'b0, v2[5:0]}, 8'h00);
        poll(19'h123, v);
        chk("R11 poll after program", v, 8'h3C);
        chk("R2 programmed byte", v, 8'h3C);

        // R3 AND behaviour
        program_byte(19'h123, 8'hF0);
        poll(19'h123, v);
        chk("R3 bits only cleared", v, 8'h30);

        // R10 hold
        repeat (3) @(negedge clk);
        chk("R10 dout holds", dout, 8'h30);

        // R2 upper address bits ignored for keys
        unlock(19'h40000 | 19'h28000);
        wr(19'h4D555, 8'hA0);
        wr(19'h40077, 8'h5A);
        poll(19'h077, v);
        chk("R2 key on low 15 bits", v, 8'h5A);

        // R6 broken sequence
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h56);
        wr(19'h05555, 8'hA0);
        wr(19'h050, 8'h00);
        rd(19'h050, v);
        chk("R6 broken sequence no effect", v, 8'hFF);
        program_byte(19'h050, 8'h11);
        poll(19'h050, v);
        chk("R6 recovery accepted", v, 8'h11);

        // R4 sector erase
        program_byte(19'h1A5, 8'h00);
        poll(19'h1A5, v);
        program_byte(19'h205, 8'h00);
        poll(19'h205, v);
        erase_prefix();
        wr(19'h1A5, 8'h30);
        rd(19'h1A5, v);
        chk("R8 sector status bit7", {7'b0, v[7]}, 8'h00);
        poll(19'h1A5, v);
        chk("R4 sector erased", v, 8'hFF);
        chk("R11 poll after erase", v, 8'hFF);
        rd(19'h205, v);
        chk("R4 next sector kept", v, 8'h00);
        rd(19'h077, v);
        chk("R4 lower sector kept", v, 8'h5A);

        // R9 writes while busy
        program_byte(19'h300, 8'h00);
        unlock(19'h0);
        wr(19'h05555, 8'hA0);
        wr(19'h301, 8'h00);
        poll(19'h300, v);
        chk("R9 busy op completes", v, 8'h00);
        rd(19'h301, v);
        chk("R9 busy write ignored", v, 8'hFF);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'hA0);
        wr(19'h302, 8'h00);
        rd(19'h302, v);
        chk("R9 sequence not advanced", v, 8'hFF);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule